// File: doc/BRIEF.md
# UART Receive FIFO and Register Readback

This block is the read half of a memory-mapped serial port. A sixteen-slot circular receive queue collects characters from the serial receiver. Each character arrives with its error bits. A small peripheral bus reads the queue, the status flags, the interrupt state and a bank of configuration words. The same bus can write the configuration words back. The shift logic, baud generation, transmit path and DMA handshakes are outside this block.

Reading the data word has side effects. It removes the oldest character and copies that character's error bits into a receive-status word. It also updates the empty and full flags, and it can drop the receive interrupt. The interrupt is raised when the fill level reaches a programmable trigger. It is cleared only when a read brings the fill level to exactly one below that trigger. Read data is combinational from the current state. All side effects take place at the clock edge that ends the access phase.

Top module: `uart_rx_regread`

## Requirements
- R1: After reset, the flag word (byte 0x018) reads 0x10, which is empty at bit 4 and full at bit 6 clear. The receive-status word, the raw interrupt word and every configuration word read 0, and `irq` is low.
- R2: When the queue is non-empty, a read of the data word (byte 0x000) returns the oldest entry. The character is in bits 7:0 and the 4 error bits are in bits 11:8. The read then removes that entry. Entries leave in arrival order, and the order holds as the read slot wraps from 15 back to 0.
- R3: The empty flag is set when a data read leaves the queue at zero, and it is cleared by an accepted push. The full flag is set when a push brings the fill level to 16, and it is cleared by every data read.
- R4: A data read on an empty queue returns the entry stored at the current read slot. This is 0 if the slot was never written. The fill level and the read slot do not change.
- R5: From the cycle after a data read, the receive-status word (byte 0x004) holds bits 11:8 of the entry that read returned.
- R6: A push while 16 entries are held is discarded, and the stored entries are unchanged.
- R7: The trigger level is the level-select word (byte 0x034) bits 3:0 plus one. The raw interrupt word (byte 0x03C) bit 4 is set when an accepted push brings the fill level equal to the trigger.
- R8: The raw receive interrupt is cleared only by a data read that leaves the fill level equal to the trigger minus one. Any other data read leaves it as it was.
- R9: The mask word (byte 0x038) reads back as written. The masked word (byte 0x040) equals raw AND mask. `irq` is the OR of the masked bits.
- R10: Writes to bytes 0x020, 0x024, 0x028, 0x02C, 0x030, 0x034, 0x038 and 0x048 store the low 16 bits, which read back with the upper bits zero. Writes to any other offset, the raw interrupt word included, change nothing.
- R11: Bytes 0xFE0 to 0xFFC return identification byte i in bits 7:0, where i = (address − 0xFE0)/4 and byte i is bits 8i+7:8i of `ID_BYTES`. Every other unmapped offset reads 0.
- R12: Side effects occur only in the access phase of a read (`psel`, `penable`, not `pwrite`). A setup phase at the data word, or a write to it, removes nothing.
- R13: A push and a data read in the same cycle both take effect. The read returns the oldest entry, the new entry joins the tail, and the fill level is unchanged. In that cycle the raw interrupt is cleared if the resulting level is the trigger minus one. Otherwise it is set if the push was accepted and the level equals the trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high, read when low |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the same cycle |
| rx_valid | input | 1 | Receive push strobe |
| rx_char | input | 8 | Received character |
| rx_err | input | 4 | Error bits of the received character |
| irq | output | 1 | Masked interrupt, OR of masked status |

## Verification
A receive push and a data-word read can land on the same clock edge. The push writes at the tail slot while the pop advances the head. The bench provokes this by raising `rx_valid` in the access phase of a data read while two entries are queued. It judges the result from several observations. The returned word must be the oldest entry. The flag word must still show the queue as neither empty nor full. Draining the queue afterwards must return the remaining old entry and then the newly pushed one, in that order.

// File: rtl/uart_rr_pkg.sv
`timescale 1ns/1ps
package uart_rr_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WORD_W = ADDR_W - 2;
    localparam int REG_W  = 16;
    localparam int CHAR_W = 8;

    // word offsets decoded by the register map
    localparam logic [WORD_W-1:0] WO_DATA  = WORD_W'(0);
    localparam logic [WORD_W-1:0] WO_RSTAT = WORD_W'(1);
    localparam logic [WORD_W-1:0] WO_FLAG  = WORD_W'(6);
    localparam logic [WORD_W-1:0] WO_LPDIV = WORD_W'(8);
    localparam logic [WORD_W-1:0] WO_IBAUD = WORD_W'(9);
    localparam logic [WORD_W-1:0] WO_FBAUD = WORD_W'(10);
    localparam logic [WORD_W-1:0] WO_LINE  = WORD_W'(11);
    localparam logic [WORD_W-1:0] WO_CTRL  = WORD_W'(12);
    localparam logic [WORD_W-1:0] WO_LEVEL = WORD_W'(13);
    localparam logic [WORD_W-1:0] WO_MASK  = WORD_W'(14);
    localparam logic [WORD_W-1:0] WO_RAW   = WORD_W'(15);
    localparam logic [WORD_W-1:0] WO_MSKD  = WORD_W'(16);
    localparam logic [WORD_W-1:0] WO_DMA   = WORD_W'(18);

    localparam int FLAG_EMPTY_BIT = 4;
    localparam int FLAG_FULL_BIT  = 6;
    localparam int IRQ_RX_BIT     = 4;

    typedef struct packed {
        logic [REG_W-1:0] lpdiv;
        logic [REG_W-1:0] ibaud;
        logic [REG_W-1:0] fbaud;
        logic [REG_W-1:0] line;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] level;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] dma;
    } cfg_t;
endpackage

// File: rtl/uart_rr_fifo.sv
`timescale 1ns/1ps
module uart_rr_fifo #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 12,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [ENTRY_W-1:0] push_data_i,
    input  logic               pop_i,
    input  logic [CNT_W-1:0]   trig_i,
    output logic [ENTRY_W-1:0] head_o,
    output logic               empty_o,
    output logic               full_o,
    output logic               raw_o
);
    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             fe;
        logic             ff;
        logic             raw;
    } st_t;

    localparam st_t ST_RST = '{rptr: '0, cnt: '0, fe: 1'b1, ff: 1'b0, raw: 1'b0};

    st_t                st_d, st_q;
    logic [ENTRY_W-1:0] mem_q [DEPTH];
    logic               push_ok, pop_ok;
    logic [CNT_W:0]     wsum;
    logic [PTR_W-1:0]   widx;

    always_comb begin
        st_d    = st_q;
        push_ok = push_i && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop_i && (st_q.cnt != '0);

        // tail slot = read slot + level, modulo depth
        wsum = (CNT_W+1)'(st_q.rptr) + (CNT_W+1)'(st_q.cnt);
        if (wsum >= (CNT_W+1)'(DEPTH)) widx = PTR_W'(wsum - (CNT_W+1)'(DEPTH));
        else                           widx = PTR_W'(wsum);

        if (pop_ok)
            st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;

        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase

        if (pop_i) st_d.ff = 1'b0;
        if (push_ok) st_d.fe = 1'b0;
        if (push_ok && st_d.cnt == CNT_W'(DEPTH)) st_d.ff = 1'b1;
        if (pop_i && st_d.cnt == '0) st_d.fe = 1'b1;

        if (pop_i && st_d.cnt == trig_i - 1'b1)      st_d.raw = 1'b0;
        else if (push_ok && st_d.cnt == trig_i)      st_d.raw = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push_ok) begin
            mem_q[widx] <= push_data_i;
        end
    end

    assign head_o  = mem_q[st_q.rptr];
    assign empty_o = st_q.fe;
    assign full_o  = st_q.ff;
    assign raw_o   = st_q.raw;
endmodule

// File: rtl/uart_rr_regs.sv
`timescale 1ns/1ps
module uart_rr_regs
    import uart_rr_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              pop_i,
    input  logic [ERR_W-1:0]  head_err_i,
    output cfg_t              cfg_o,
    output logic [ERR_W-1:0]  rsr_o
);
    typedef struct packed {
        cfg_t             cfg;
        logic [ERR_W-1:0] rsr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (word_i)
                WO_LPDIV: st_d.cfg.lpdiv = wdata_i;
                WO_IBAUD: st_d.cfg.ibaud = wdata_i;
                WO_FBAUD: st_d.cfg.fbaud = wdata_i;
                WO_LINE:  st_d.cfg.line  = wdata_i;
                WO_CTRL:  st_d.cfg.ctrl  = wdata_i;
                WO_LEVEL: st_d.cfg.level = wdata_i;
                WO_MASK:  st_d.cfg.mask  = wdata_i;
                WO_DMA:   st_d.cfg.dma   = wdata_i;
                default:  ;
            endcase
        end
        if (pop_i) st_d.rsr = head_err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign rsr_o = st_q.rsr;
endmodule

// File: rtl/uart_rr_rdmux.sv
`timescale 1ns/1ps
module uart_rr_rdmux
    import uart_rr_pkg::*;
#(
    parameter int          ENTRY_W  = 12,
    parameter int          ERR_W    = 4,
    parameter logic [63:0] ID_BYTES = 64'h5AC3_0FE1_0037_9248
) (
    input  logic [WORD_W-1:0]  word_i,
    input  cfg_t               cfg_i,
    input  logic [ERR_W-1:0]   rsr_i,
    input  logic [ENTRY_W-1:0] head_i,
    input  logic               empty_i,
    input  logic               full_i,
    input  logic               raw_i,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int ID_WORDS = 8;

    logic [7:0]       id_tab [ID_WORDS];
    logic [REG_W-1:0] raw_vec;
    logic [REG_W-1:0] flags;

    for (genvar g = 0; g < ID_WORDS; g++) begin : g_id
        assign id_tab[g] = ID_BYTES[8*g +: 8];
    end

    always_comb begin
        raw_vec = '0;
        raw_vec[IRQ_RX_BIT] = raw_i;
        flags = '0;
        flags[FLAG_EMPTY_BIT] = empty_i;
        flags[FLAG_FULL_BIT]  = full_i;

        rdata_o = '0;
        if (&word_i[WORD_W-1:3]) begin
            rdata_o = DATA_W'(id_tab[word_i[2:0]]);
        end else begin
            case (word_i)
                WO_DATA:  rdata_o = DATA_W'(head_i);
                WO_RSTAT: rdata_o = DATA_W'(rsr_i);
                WO_FLAG:  rdata_o = DATA_W'(flags);
                WO_LPDIV: rdata_o = DATA_W'(cfg_i.lpdiv);
                WO_IBAUD: rdata_o = DATA_W'(cfg_i.ibaud);
                WO_FBAUD: rdata_o = DATA_W'(cfg_i.fbaud);
                WO_LINE:  rdata_o = DATA_W'(cfg_i.line);
                WO_CTRL:  rdata_o = DATA_W'(cfg_i.ctrl);
                WO_LEVEL: rdata_o = DATA_W'(cfg_i.level);
                WO_MASK:  rdata_o = DATA_W'(cfg_i.mask);
                WO_RAW:   rdata_o = DATA_W'(raw_vec);
                WO_MSKD:  rdata_o = DATA_W'(raw_vec & cfg_i.mask);
                WO_DMA:   rdata_o = DATA_W'(cfg_i.dma);
                default:  rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_regread.sv
`timescale 1ns/1ps
module uart_rx_regread
    import uart_rr_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter int          ERR_W    = 4,
    parameter logic [63:0] ID_BYTES = 64'h5AC3_0FE1_0037_9248
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [ERR_W-1:0]  rx_err,
    output logic              irq
);
    localparam int ENTRY_W = CHAR_W + ERR_W;
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);

    logic [WORD_W-1:0]  word;
    logic               rd_stb, wr_stb, pop_stb;
    logic [CNT_W-1:0]   trig;
    logic [ENTRY_W-1:0] fifo_head;
    logic               fifo_empty, fifo_full, rx_raw;
    logic [ERR_W-1:0]   rsr_q;
    cfg_t               cfg;
    logic [REG_W-1:0]   raw_vec;
    logic               unused_bits;

    assign word    = paddr[ADDR_W-1:2];
    assign rd_stb  = psel && penable && !pwrite;
    assign wr_stb  = psel && penable && pwrite;
    assign pop_stb = rd_stb && (word == WO_DATA);
    assign trig    = CNT_W'(cfg.level[PTR_W-1:0]) + CNT_W'(1);
    assign unused_bits = ^{paddr[1:0], pwdata[DATA_W-1:REG_W]};

    uart_rr_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rx_valid),
        .push_data_i ({rx_err, rx_char}),
        .pop_i       (pop_stb),
        .trig_i      (trig),
        .head_o      (fifo_head),
        .empty_o     (fifo_empty),
        .full_o      (fifo_full),
        .raw_o       (rx_raw)
    );

    uart_rr_regs #(.ERR_W(ERR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_stb),
        .word_i     (word),
        .wdata_i    (pwdata[REG_W-1:0]),
        .pop_i      (pop_stb),
        .head_err_i (fifo_head[ENTRY_W-1:CHAR_W]),
        .cfg_o      (cfg),
        .rsr_o      (rsr_q)
    );

    uart_rr_rdmux #(.ENTRY_W(ENTRY_W), .ERR_W(ERR_W), .ID_BYTES(ID_BYTES)) u_rdmux (
        .word_i  (word),
        .cfg_i   (cfg),
        .rsr_i   (rsr_q),
        .head_i  (fifo_head),
        .empty_i (fifo_empty),
        .full_i  (fifo_full),
        .raw_i   (rx_raw),
        .rdata_o (prdata)
    );

    always_comb begin
        raw_vec = '0;
        raw_vec[IRQ_RX_BIT] = rx_raw;
    end

    assign irq = |(raw_vec & cfg.mask);
endmodule

// File: rtl/uart_rr_chk.sv
`timescale 1ns/1ps
module uart_rr_chk #(
    parameter int ENTRY_W = 12,
    parameter int ERR_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pop,
    input logic               push,
    input logic               fe,
    input logic               ff,
    input logic               raw,
    input logic [ENTRY_W-1:0] head,
    input logic [ERR_W-1:0]   rsr
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe && ff)); // R3

    AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> !fe); // R3

    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !ff); // R3

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        pop && fe && !push |=> fe && $stable(head)); // R4

    AST_STATUS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> rsr == $past(head[ENTRY_W-1:ENTRY_W-ERR_W])); // R5

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ff && !pop |=> ff && $stable(head)); // R6

    AST_RAW_RISE_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(push)); // R7

    AST_RAW_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw) |-> $past(pop)); // R8
endmodule

bind uart_rx_regread uart_rr_chk #(.ENTRY_W(ENTRY_W), .ERR_W(ERR_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .pop  (pop_stb),
    .push (rx_valid),
    .fe   (fifo_empty),
    .ff   (fifo_full),
    .raw  (rx_raw),
    .head (fifo_head),
    .rsr  (rsr_q)
);

// File: tb/uart_rx_regread_test.sv
`timescale 1ns/1ps
module uart_rx_regread_test;
    localparam logic [63:0] IDV = 64'h5AC3_0FE1_0037_9248;

    logic        clk = 1'b0;
    logic        rst_n, psel, penable, pwrite, rx_valid, irq;
    logic [11:0] paddr;
    logic [31:0] pwdata, prdata;
    logic [7:0]  rx_char;
    logic [3:0]  rx_err;

    always #10 clk = ~clk;

    uart_rx_regread #(.DEPTH(16), .ERR_W(4), .ID_BYTES(IDV)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_err(rx_err), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    // scoreboard: expected queue plus a shadow of every slot for stale reads
    logic [11:0] exp_q[$];
    logic [11:0] shadow [16];
    int          sh_r = 0, sh_w = 0;
    logic [3:0]  m_rsr = '0;
    bit          m_raw = 1'b0;
    int          trig = 1;
    logic [15:0] m_mask = '0;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [11:0] model_step(bit pop, bit push, logic [11:0] e);
        logic [11:0] rd;
        int n;
        n  = exp_q.size();
        rd = (n > 0) ? exp_q[0] : shadow[sh_r];
        if (pop && n > 0) begin
            void'(exp_q.pop_front());
            sh_r = (sh_r + 1) % 16;
        end
        if (push && n < 16) begin
            exp_q.push_back(e);
            shadow[sh_w] = e;
            sh_w = (sh_w + 1) % 16;
        end
        if (pop) m_rsr = rd[11:8];
        if (pop && exp_q.size() == trig - 1) m_raw = 1'b0;
        else if (push && n < 16 && exp_q.size() == trig) m_raw = 1'b1;
        return rd;
    endfunction

    task automatic do_push(input logic [7:0] c, input logic [3:0] er);
        logic [11:0] unused_rd;
        rx_char = c; rx_err = er; rx_valid = 1'b1;
        unused_rd = model_step(1'b0, 1'b1, {er, c});
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #2 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] v);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = v;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        if (a == 12'h034) trig = int'(v[3:0]) + 1;
        if (a == 12'h038) m_mask = v[15:0];
    endtask

    task automatic rd_data(input string req);
        logic [31:0] d;
        logic [11:0] e;
        bus_rd(12'h000, d);
        e = model_step(1'b1, 1'b0, '0);
        check(req, d, 32'(e));
    endtask

    task automatic rd_data_with_push(input logic [7:0] c, input logic [3:0] er, input string req);
        logic [31:0] d;
        logic [11:0] e;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h000;
        @(negedge clk);
        penable = 1'b1; rx_valid = 1'b1; rx_char = c; rx_err = er;
        #2 d = prdata;
        e = model_step(1'b1, 1'b1, {er, c});
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; rx_valid = 1'b0;
        check(req, d, 32'(e));
    endtask

    task automatic chk_flags(input string req);
        logic [31:0] d, exp;
        bus_rd(12'h018, d);
        exp = '0;
        if (exp_q.size() == 16) exp[6] = 1'b1;
        if (exp_q.size() == 0)  exp[4] = 1'b1;
        check(req, d, exp);
    endtask

    task automatic chk_raw(input string req);
        logic [31:0] d;
        bus_rd(12'h03C, d);
        check(req, d, {27'b0, m_raw, 4'b0});
        check(req, {31'b0, irq}, {31'b0, m_raw & m_mask[4]});
        bus_rd(12'h040, d);
        check(req, d, {16'b0, m_mask & {11'b0, m_raw, 4'b0}});
    endtask

    task automatic chk_reg(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        bus_rd(a, d);
        check(req, d, exp);
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; rx_valid = 1'b0; rx_char = '0; rx_err = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk_flags("R1 flags");
        chk_reg(12'h004, 32'h0, "R1 rstat");
        chk_reg(12'h034, 32'h0, "R1 level");
        chk_reg(12'h020, 32'h0, "R1 lpdiv");
        chk_raw("R1 raw");
        // R4 empty read right after reset
        rd_data("R4 empty read after reset");
        chk_flags("R4 flags after empty read");

        // R7 / R9 trigger at level 4, mask enabled
        bus_wr(12'h034, 32'h3);
        bus_wr(12'h038, 32'h10);
        chk_reg(12'h038, 32'h10, "R9 mask readback");
        do_push(8'h41, 4'h0);
        do_push(8'h42, 4'h5);
        do_push(8'h43, 4'hA);
        chk_raw("R7 below trigger");
        do_push(8'h44, 4'h3);
        chk_raw("R7 reached trigger");
        do_push(8'h45, 4'hF);

        // R2 / R5 / R8
        rd_data("R2 oldest first");
        chk_reg(12'h004, {28'b0, m_rsr}, "R5 status after read");
        chk_raw("R8 level equals trigger keeps raw");
        rd_data("R2 second entry");
        chk_reg(12'h004, {28'b0, m_rsr}, "R5 status second");
        chk_raw("R8 level trigger minus one clears");

        // R9 masked off while raw set
        bus_wr(12'h038, 32'h0);
        do_push(8'h46, 4'h1);
        chk_raw("R9 raw set but masked");
        bus_wr(12'h038, 32'h10);
        chk_raw("R9 unmasked again");

        // R3 / R6 fill to full
        while (exp_q.size() < 16) do_push(8'h50 + 8'(exp_q.size()), 4'(exp_q.size()));
        chk_flags("R3 full flag");
        do_push(8'hEE, 4'hE);
        chk_flags("R6 push into full dropped");
        rd_data("R3 first read from full");
        chk_flags("R3 read clears full");
        while (exp_q.size() > 0) rd_data("R2 drain across wrap");
        chk_flags("R3 empty after drain");
        chk_raw("R8 after drain");

        // R4 stale read on empty
        rd_data("R4 empty stale entry");
        rd_data("R4 second empty read unchanged");
        chk_flags("R4 still empty");

        // R10 writable words
        bus_wr(12'h020, 32'hABCD_1234);
        bus_wr(12'h024, 32'h0000_0271);
        bus_wr(12'h028, 32'h0000_0015);
        bus_wr(12'h02C, 32'h0000_0070);
        bus_wr(12'h030, 32'h0000_0301);
        bus_wr(12'h048, 32'h0000_0005);
        bus_wr(12'h034, 32'h0000_0005);
        chk_reg(12'h020, 32'h1234, "R10 lpdiv upper bits dropped");
        chk_reg(12'h024, 32'h0271, "R10 ibaud");
        chk_reg(12'h028, 32'h0015, "R10 fbaud");
        chk_reg(12'h02C, 32'h0070, "R10 line");
        chk_reg(12'h030, 32'h0301, "R10 ctrl");
        chk_reg(12'h048, 32'h0005, "R10 dma");
        chk_reg(12'h034, 32'h0005, "R10 level");
        bus_wr(12'h03C, 32'hFFFF);
        chk_raw("R10 raw word not writable");
        bus_wr(12'h044, 32'h1234);
        chk_reg(12'h044, 32'h0, "R10 unmapped write ignored");

        // R11 identification and unmapped words
        for (int i = 0; i < 8; i++)
            chk_reg(12'hFE0 + 12'(4 * i), {24'b0, IDV[8*i +: 8]}, "R11 id word");
        chk_reg(12'h008, 32'h0, "R11 unmapped 0x008");
        chk_reg(12'h080, 32'h0, "R11 unmapped 0x080");
        chk_reg(12'hFDC, 32'h0, "R11 unmapped 0xFDC");

        // R12 non-read accesses leave the queue alone
        do_push(8'h77, 4'h9);
        bus_wr(12'h000, 32'h00FF);
        chk_flags("R12 write to data word");
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h000;
        @(negedge clk);
        psel = 1'b0;
        chk_flags("R12 setup phase only");
        rd_data("R12 entry survives");

        // R13 push and read together
        do_push(8'h81, 4'h2);
        do_push(8'h82, 4'h4);
        rd_data_with_push(8'h83, 4'h6, "R13 read returns oldest");
        chk_flags("R13 level unchanged");
        chk_raw("R13 raw state");
        rd_data("R13 remaining old entry");
        rd_data("R13 pushed entry last");
        chk_flags("R13 empty after drain");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule